// File: doc/BRIEF.md
# Trap Dispatch and Vector Generator

This block takes a pending trap and decides which handler mode services it, then forms the handler's fetch address and the address that follows it. It looks at the current trap level, the processor's hyperprivileged, privileged and reset-error status bits, the trap number, a per-trap code naming the target mode for each possible current mode, and the two handler base registers. It reports a route, the trap number actually used to index the handler table, the handler PC and NPC, and one strobe that tells the state-holding logic to apply power-on initial values.

A trap request or a power-on request is a single-cycle pulse. One clock later the result appears together with a one-cycle valid strobe. The results then hold until the next request. Saving the interrupted state and loading the trap-level registers is left to the surrounding logic. That logic uses the route and the power-on strobe to decide what to write.

Top module: `trap_dispatch`

## Requirements
- R1: A request (`trap_req_i` or `por_i` high at a rising edge) produces `valid_o` high for exactly the following cycle, and the other outputs are updated at that edge. Without a request, `valid_o` is low in the next cycle.
- R2: The current mode is hyper when `hpriv_i` is set, else privileged when `priv_i` is set, else user. `tgt_code_i[1:0]`, `[3:2]` and `[5:4]` give the target code for current user, privileged and hyper mode. Code 0 targets privileged. Code 1 targets hyper from hyper mode and privileged otherwise. Codes 2 and 3 target hyper.
- R3: If `red_i` is set, or the trap level equals MAX_TL-1, the route is RED (code 0) and the effective trap number is 5. The PC is 0xFFF0000000 ORed with (number<<5)&0xFF, which gives 0xFFF00000A0.
- R4: If R3 does not apply and the trap level is MAX_TL or above, the route is ERROR (code 3), the effective number is the input trap number, and PC and NPC are 0.
- R5: If R3 and R4 do not apply, the trap level exceeds MAX_PTL and the target is privileged, the route is hyper (code 1) with effective number 2.
- R6: Otherwise, if the target is hyper, or the target is privileged and the trap number is 384 or more, the route is hyper with the input trap number. In all remaining cases the route is privileged (code 2) with the input trap number.
- R7: On the hyper route, the PC is HTBA with bits 13:0 cleared, ORed with (number<<5) kept to 14 bits.
- R8: On the privileged route, the PC is TBA with bits 14:0 cleared, ORed with (number<<5) kept to 14 bits, with bit 14 set when the current trap level is 1 or more.
- R9: On every route except ERROR, NPC equals PC+4.
- R10: `por_i` takes precedence over `trap_req_i`. It gives route RED, effective number 1, PC 0xFFF0000020 and `por_init_o` high for that one result cycle only.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | Trap request pulse |
| por_i | input | 1 | Power-on reset request pulse |
| tl_i | input | TLW | Current trap level |
| hpriv_i | input | 1 | Hyperprivileged status bit |
| priv_i | input | 1 | Privileged status bit |
| red_i | input | 1 | Reset/error status bit |
| tt_i | input | TTW | Trap number |
| tgt_code_i | input | 6 | Target-mode codes for user, privileged and hyper |
| tba_i | input | AW | Privileged handler base |
| htba_i | input | AW | Hyper handler base |
| valid_o | output | 1 | Result strobe |
| route_o | output | 2 | 0 RED, 1 hyper, 2 privileged, 3 error |
| eff_tt_o | output | TTW | Trap number used for the vector |
| pc_o | output | AW | Handler PC |
| npc_o | output | AW | Handler NPC |
| por_init_o | output | 1 | Apply power-on initial state |

## Verification
The bench sweeps every trap level from 0 to 7 against all status-bit combinations, all four target codes and trap numbers on both sides of 384. It compares each result with values worked out arithmetically from the requirements. Trap level MAX_TL-1 and MAX_TL are the sharpest edges: an off-by-one in either test would send a trap to an error where a RED vector belongs, or the reverse. Level MAX_PTL+1 with a privileged target checks the guest-watchdog redirect, which a design missing it would send to the privileged table. The 383/384 pair catches a wrong cutoff. Level 0 against level 1 on the privileged route checks bit 14, which a design testing the new level rather than the current one would set one level too early. Power-on with a simultaneous trap request checks precedence and that the init strobe lasts one cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    RT_RED  = 2'd0,
    RT_HYP  = 2'd1,
    RT_PRIV = 2'd2,
    RT_ERR  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    MD_USER = 2'd0,
    MD_PRIV = 2'd1,
    MD_HYP  = 2'd2
  } mode_e;

  localparam logic [39:0] RED_BASE   = 40'hFF_F000_0000;
  localparam int unsigned TT_RED     = 5;
  localparam int unsigned TT_GWDOG   = 2;
  localparam int unsigned TT_POR     = 1;
  localparam int unsigned HYP_TT_CUT = 384;
endpackage

// File: rtl/trap_mode_sel.sv
module trap_mode_sel
  import trap_pkg::*;
(
  input  logic       hpriv_i,
  input  logic       priv_i,
  input  logic [5:0] tgt_code_i,
  output mode_e      target_o
);
  mode_e      cur;
  logic [1:0] code;

  always_comb begin
    if (hpriv_i)     cur = MD_HYP;
    else if (priv_i) cur = MD_PRIV;
    else             cur = MD_USER;
  end

  always_comb begin
    unique case (cur)
      MD_HYP:  code = tgt_code_i[5:4];
      MD_PRIV: code = tgt_code_i[3:2];
      default: code = tgt_code_i[1:0];
    endcase
  end

  // code 1: stay in hyper if already there, else go privileged
  always_comb begin
    unique case (code)
      2'd0:    target_o = MD_PRIV;
      2'd1:    target_o = (cur == MD_HYP) ? MD_HYP : MD_PRIV;
      default: target_o = MD_HYP;
    endcase
  end
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int unsigned TLW     = 3,
  parameter int unsigned TTW     = 9,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic [TLW-1:0] tl_i,
  input  logic           red_i,
  input  logic           por_i,
  input  logic [TTW-1:0] tt_i,
  input  mode_e          target_i,
  output route_e         route_o,
  output logic [TTW-1:0] vec_tt_o
);
  localparam logic [TLW-1:0] TL_RED = TLW'(MAX_TL - 1);
  localparam logic [TLW-1:0] TL_ERR = TLW'(MAX_TL);
  localparam logic [TLW-1:0] TL_PTL = TLW'(MAX_PTL);
  localparam logic [TTW-1:0] TT_CUT = TTW'(HYP_TT_CUT);

  always_comb begin
    route_o  = RT_PRIV;
    vec_tt_o = tt_i;
    if (por_i) begin
      route_o  = RT_RED;
      vec_tt_o = TTW'(TT_POR);
    end else if (red_i || tl_i == TL_RED) begin
      route_o  = RT_RED;
      vec_tt_o = TTW'(TT_RED);
    end else if (tl_i >= TL_ERR) begin
      route_o  = RT_ERR;
    end else if (tl_i > TL_PTL && target_i == MD_PRIV) begin
      route_o  = RT_HYP;
      vec_tt_o = TTW'(TT_GWDOG);
    end else if (target_i == MD_HYP || tt_i >= TT_CUT) begin
      route_o  = RT_HYP;
    end
  end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int unsigned AW  = 64,
  parameter int unsigned TLW = 3,
  parameter int unsigned TTW = 9
) (
  input  route_e         route_i,
  input  logic [TTW-1:0] vec_tt_i,
  input  logic [TLW-1:0] tl_i,
  input  logic [AW-1:0]  tba_i,
  input  logic [AW-1:0]  htba_i,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  npc_o
);
  localparam logic [AW-1:0] M14   = AW'(14'h3FFF);
  localparam logic [AW-1:0] M15   = AW'(15'h7FFF);
  localparam logic [AW-1:0] BIT14 = AW'(15'h4000);
  localparam logic [AW-1:0] M8    = AW'(8'hFF);

  logic [AW-1:0] tt_sh;
  assign tt_sh = AW'(vec_tt_i) << 5;

  always_comb begin
    unique case (route_i)
      RT_RED:  pc_o = AW'(RED_BASE) | (tt_sh & M8);
      RT_HYP:  pc_o = (htba_i & ~M14) | (tt_sh & M14);
      RT_PRIV: pc_o = (tba_i & ~M15) | ((tl_i != '0) ? BIT14 : '0) | (tt_sh & M14);
      default: pc_o = '0;
    endcase
    npc_o = (route_i == RT_ERR) ? '0 : pc_o + AW'(4);
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int unsigned AW      = 64,
  parameter int unsigned TTW     = 9,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2,
  localparam int unsigned TLW    = $clog2(MAX_TL + 2)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trap_req_i,
  input  logic           por_i,
  input  logic [TLW-1:0] tl_i,
  input  logic           hpriv_i,
  input  logic           priv_i,
  input  logic           red_i,
  input  logic [TTW-1:0] tt_i,
  input  logic [5:0]     tgt_code_i,
  input  logic [AW-1:0]  tba_i,
  input  logic [AW-1:0]  htba_i,
  output logic           valid_o,
  output logic [1:0]     route_o,
  output logic [TTW-1:0] eff_tt_o,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  npc_o,
  output logic           por_init_o
);
  mode_e          target;
  route_e         route_d;
  logic [TTW-1:0] vec_tt;
  logic [AW-1:0]  pc_d, npc_d;

  trap_mode_sel u_mode (
    .hpriv_i    (hpriv_i),
    .priv_i     (priv_i),
    .tgt_code_i (tgt_code_i),
    .target_o   (target)
  );

  trap_router #(.TLW(TLW), .TTW(TTW), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) u_route (
    .tl_i     (tl_i),
    .red_i    (red_i),
    .por_i    (por_i),
    .tt_i     (tt_i),
    .target_i (target),
    .route_o  (route_d),
    .vec_tt_o (vec_tt)
  );

  trap_vec_gen #(.AW(AW), .TLW(TLW), .TTW(TTW)) u_vec (
    .route_i  (route_d),
    .vec_tt_i (vec_tt),
    .tl_i     (tl_i),
    .tba_i    (tba_i),
    .htba_i   (htba_i),
    .pc_o     (pc_d),
    .npc_o    (npc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      por_init_o <= 1'b0;
      route_o    <= '0;
      eff_tt_o   <= '0;
      pc_o       <= '0;
      npc_o      <= '0;
    end else begin
      valid_o    <= trap_req_i | por_i;
      por_init_o <= por_i;
      if (trap_req_i | por_i) begin
        route_o  <= route_d;
        eff_tt_o <= vec_tt;
        pc_o     <= pc_d;
        npc_o    <= npc_d;
      end
    end
  end
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
  parameter int unsigned AW  = 64,
  parameter int unsigned TTW = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           trap_req_i,
  input logic           por_i,
  input logic           red_i,
  input logic           valid_o,
  input logic [1:0]     route_o,
  input logic [TTW-1:0] eff_tt_o,
  input logic [AW-1:0]  pc_o,
  input logic [AW-1:0]  npc_o,
  input logic           por_init_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i || por_i) |=> valid_o);                                        // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_req_i || por_i) |=> !valid_o);                                      // R1
  AST_RED_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && !por_i && red_i) |=> (route_o == 2'd0 && eff_tt_o == TTW'(5))); // R3
  AST_ERR_NO_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && route_o == 2'd3) |-> (pc_o == '0 && npc_o == '0));            // R4
  AST_HYP_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && route_o == 2'd1) |-> (pc_o[TTW+4:0] == {eff_tt_o, 5'b0}));    // R7
  AST_NPC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && route_o != 2'd3) |-> (npc_o == pc_o + AW'(4)));               // R9
  AST_POR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (por_init_o && route_o == 2'd0 && eff_tt_o == TTW'(1)));        // R10
  AST_POR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_i |=> !por_init_o);                                                   // R10
endmodule

bind trap_dispatch trap_dispatch_chk #(.AW(AW), .TTW(TTW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_req_i (trap_req_i),
  .por_i      (por_i),
  .red_i      (red_i),
  .valid_o    (valid_o),
  .route_o    (route_o),
  .eff_tt_o   (eff_tt_o),
  .pc_o       (pc_o),
  .npc_o      (npc_o),
  .por_init_o (por_init_o)
);

// File: tb/trap_dispatch_tb_top.sv
`timescale 1ns/1ps
module trap_dispatch_tb_top;
  localparam int AW = 64, TTW = 9, MAX_TL = 6, MAX_PTL = 2, TLW = 3;
  localparam logic [63:0] TBA  = 64'hA5A5_1234_5678_FFFF;
  localparam logic [63:0] HTBA = 64'h0123_4567_89AB_FFFF;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic trap_req_i = 1'b0, por_i = 1'b0;
  logic [TLW-1:0] tl_i = '0;
  logic hpriv_i = 1'b0, priv_i = 1'b0, red_i = 1'b0;
  logic [TTW-1:0] tt_i = '0;
  logic [5:0] tgt_code_i = '0;
  logic [AW-1:0] tba_i = TBA, htba_i = HTBA;
  logic valid_o, por_init_o;
  logic [1:0] route_o;
  logic [TTW-1:0] eff_tt_o;
  logic [AW-1:0] pc_o, npc_o;

  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  trap_dispatch #(.AW(AW), .TTW(TTW), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) dut_i (
    .clk_i, .rst_ni, .trap_req_i, .por_i, .tl_i, .hpriv_i, .priv_i, .red_i,
    .tt_i, .tgt_code_i, .tba_i, .htba_i, .valid_o, .route_o, .eff_tt_o,
    .pc_o, .npc_o, .por_init_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input int tl, input bit hp, input bit pr, input bit rd,
                       input logic [5:0] code, input int tt,
                       output int rt, output int ett, output logic [63:0] pc, output string tag);
    int cur, c, tgt;  // modes: 0 user, 1 priv, 2 hyper
    cur = hp ? 2 : (pr ? 1 : 0);
    c = int'(code >> (2 * cur)) & 3;
    tgt = (c == 0) ? 1 : (c == 1) ? ((cur == 2) ? 2 : 1) : 2;
    ett = tt;
    if (rd || tl == MAX_TL - 1) begin
      rt = 0; ett = 5; tag = "R3";
    end else if (tl >= MAX_TL) begin
      rt = 3; tag = "R4";
    end else if (tl > MAX_PTL && tgt == 1) begin
      rt = 1; ett = 2; tag = "R5";
    end else if (tgt == 2 || tt >= 384) begin
      rt = 1; tag = "R2,R6,R7";
    end else begin
      rt = 2; tag = "R2,R6,R8";
    end
    case (rt)
      0: pc = 64'hFF_F000_0000 | ((64'(ett) << 5) & 64'hFF);
      1: pc = (HTBA & ~64'h3FFF) | ((64'(ett) << 5) & 64'h3FFF);
      2: pc = (TBA & ~64'h7FFF) | ((tl >= 1) ? 64'h4000 : 64'h0) | ((64'(ett) << 5) & 64'h3FFF);
      default: pc = 64'h0;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tts[6] = '{16, 36, 127, 383, 384, 511};
    int rt, ett;
    logic [63:0] epc;
    string tag;
    repeat (2) @(negedge clk_i);
    // R11 reset values
    chk(valid_o == 0 && route_o == 0 && pc_o == 0 && npc_o == 0 && por_init_o == 0 && eff_tt_o == 0,
        "R11 reset", {valid_o, route_o, por_init_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 0, "R1 idle", valid_o, 0);

    for (int tl = 0; tl < 8; tl++)
      for (int st = 0; st < 8; st++)
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 6; k++) begin
            logic [5:0] code;
            code = {2'(c), 2'((c + 1) % 4), 2'((c + 2) % 4)};
            if (st[2]) code = {2'((c + 2) % 4), 2'(c), 2'((c + 3) % 4)};
            if (st[1]) code = {2'(c), 2'((c + 3) % 4), 2'((c + 1) % 4)};
            tl_i = TLW'(tl); hpriv_i = st[0]; priv_i = st[1]; red_i = st[2];
            tt_i = TTW'(tts[k]); tgt_code_i = code; trap_req_i = 1'b1;
            model(tl, st[0], st[1], st[2], code, tts[k], rt, ett, epc, tag);
            @(negedge clk_i);
            trap_req_i = 1'b0;
            chk(valid_o == 1, "R1 valid", valid_o, 1);
            chk(route_o == 2'(rt), tag, route_o, rt);
            chk(eff_tt_o == TTW'(ett), tag, eff_tt_o, ett);
            chk(pc_o == epc, tag, pc_o, epc);
            chk(npc_o == ((rt == 3) ? 64'h0 : epc + 4), (rt == 3) ? "R4" : "R9", npc_o,
                (rt == 3) ? 64'h0 : epc + 4);
            chk(por_init_o == 0, "R10 no init on trap", por_init_o, 0);
            @(negedge clk_i);
            chk(valid_o == 0, "R1 one cycle", valid_o, 0);
          end

    // R10 power-on, alone and with a trap request
    for (int both = 0; both < 2; both++) begin
      tl_i = 0; red_i = 0; hpriv_i = 0; priv_i = 0; tt_i = 9'd300;
      por_i = 1'b1; trap_req_i = 1'(both);
      @(negedge clk_i);
      por_i = 1'b0; trap_req_i = 1'b0;
      chk(valid_o && por_init_o, "R10 strobe", {valid_o, por_init_o}, 2'b11);
      chk(route_o == 0 && eff_tt_o == 1, "R10 route", {route_o, eff_tt_o}, 11'd1);
      chk(pc_o == 64'hFF_F000_0020, "R10 pc", pc_o, 64'hFF_F000_0020);
      chk(npc_o == 64'hFF_F000_0024, "R9 por npc", npc_o, 64'hFF_F000_0024);
      @(negedge clk_i);
      chk(!por_init_o && !valid_o, "R10 one cycle", {valid_o, por_init_o}, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule